// File: doc/BRIEF.md
# UART Channel-Mode Router and Control Decoder

This block sits between a UART's serial line receiver, the host-visible data register and the two byte FIFOs (receive and transmit). It holds the control register and the channel-mode field. Based on the selected mode, it decides which FIFO, if any, takes each received line byte and each host write to the data register. The bit framing and the FIFO storage sit outside the block. It sees the FIFOs only through their full and empty flags, and it drives them through push and pop strobes with their data.

The control register holds the receive and transmit enable and disable bits and the break start and stop bits. It also has three self-clearing bits. When written as one, each of these produces a single-cycle pulse: a receive FIFO reset, a transmit FIFO reset and a restart of the receive timeout counter. The mode field selects one of four routes: normal, echo, local loopback or remote loopback. A break seen on the line is loaded into the receive FIFO as a zero byte. The block requests a break on the outgoing line while start-break is set and stop-break is clear.

Top module: `uart_chan_router`

## Requirements
- R1: After reset the control readback is 0x128 (receive disabled, transmit disabled, stop-break set), break_o is low, no pulse is asserted and the mode readback is 0 (normal).
- R2: A control write with bit 0, bit 1 or bit 6 set produces a one-cycle high on rx_rst_o, tx_rst_o or to_restart_o respectively, in the cycle after the write. Those bits always read back as zero.
- R3: The receive path is active only when control bit 2 (enable) is 1 and bit 3 (disable) is 0. The transmit path is active only when bit 4 is 1 and bit 5 is 0. An inactive path gets no push and no pop.
- R4: Mode bits 9:8 encode 0 normal, 1 echo, 2 local loopback and 3 remote loopback. An accepted line byte is pushed to the receive FIFO in modes 0 and 1, and to the transmit FIFO in modes 1 and 3.
- R5: A host write to the data register pushes the transmit FIFO in mode 0 and the receive FIFO in mode 2. In modes 1 and 3 it is dropped.
- R6: break_o is high exactly while control bit 7 is 1 and bit 8 is 0.
- R7: A received break pushes a zero byte into the receive FIFO in every mode. While it is present, line_ready_o is low, and a mode-2 host write in the same cycle is dropped.
- R8: line_ready_o is low whenever a FIFO targeted by the current mode is full. No push reaches a full FIFO.
- R9: A host read pops the receive FIFO only when the receive path is active and the FIFO is not empty, and returns the FIFO head. Otherwise host_rdata_o is zero.
- R10: In the cycle that a FIFO's reset pulse is high, no push or pop reaches that FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | REG_W | Control write data |
| ctrl_rdata_o | output | REG_W | Control register readback |
| mode_we_i | input | 1 | Mode register write strobe |
| mode_wdata_i | input | REG_W | Mode write data (field at bits 9:8) |
| mode_o | output | 2 | Current channel mode |
| line_valid_i | input | 1 | Received line byte strobe |
| line_data_i | input | DATA_W | Received line byte |
| line_break_i | input | 1 | Received break condition strobe |
| line_ready_o | output | 1 | Line byte can be accepted this cycle |
| host_wr_i | input | 1 | Host write to the data register |
| host_wdata_i | input | DATA_W | Host write byte |
| host_rd_i | input | 1 | Host read of the data register |
| host_rdata_o | output | DATA_W | Host read byte |
| rx_full_i | input | 1 | Receive FIFO full |
| rx_empty_i | input | 1 | Receive FIFO empty |
| rx_head_i | input | DATA_W | Receive FIFO head byte |
| tx_full_i | input | 1 | Transmit FIFO full |
| rx_push_o | output | 1 | Receive FIFO push |
| rx_push_data_o | output | DATA_W | Receive FIFO push byte |
| rx_pop_o | output | 1 | Receive FIFO pop |
| tx_push_o | output | 1 | Transmit FIFO push |
| tx_push_data_o | output | DATA_W | Transmit FIFO push byte |
| rx_rst_o | output | 1 | Receive FIFO reset pulse |
| tx_rst_o | output | 1 | Transmit FIFO reset pulse |
| to_restart_o | output | 1 | Receive timeout restart pulse |
| break_o | output | 1 | Break request on the outgoing line |

## Verification
The receive FIFO has three possible writers: the line byte, the received break and a loopback host write. Two of them can land in the same cycle. A break alongside a valid line byte in normal mode, or a break alongside a host write in local loopback, must let only the zero byte through. The bench covers these by sweeping every mode and every enable/disable combination against all input strobe and flag patterns, and compares each push strobe and push byte with a model computed from the requirements. A second overlap is a FIFO reset pulse arriving in the same cycle as a line byte. The bench holds a line byte valid across a control write that resets the receive FIFO and checks that the push is absent in the pulse cycle and present in the next one.

// File: rtl/uart_chan_pkg.sv
package uart_chan_pkg;
  typedef enum logic [1:0] {
    CH_NORMAL    = 2'd0,
    CH_ECHO      = 2'd1,
    CH_LOCAL_LB  = 2'd2,
    CH_REMOTE_LB = 2'd3
  } ch_mode_e;

  localparam int CTRL_W    = 9;
  localparam int B_RX_RST  = 0;
  localparam int B_TX_RST  = 1;
  localparam int B_RX_EN   = 2;
  localparam int B_RX_DIS  = 3;
  localparam int B_TX_EN   = 4;
  localparam int B_TX_DIS  = 5;
  localparam int B_TO_RST  = 6;
  localparam int B_BRK_GO  = 7;
  localparam int B_BRK_END = 8;
  localparam int MODE_LSB  = 8;

  localparam logic [CTRL_W-1:0] CTRL_RESET = 9'h128;
  localparam logic [CTRL_W-1:0] CTRL_SELF_CLR =
    CTRL_W'((1 << B_RX_RST) | (1 << B_TX_RST) | (1 << B_TO_RST));
endpackage

// File: rtl/uart_ctrl_reg.sv
module uart_ctrl_reg
  import uart_chan_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic             rx_act_o,
  output logic             tx_act_o,
  output logic             brk_o,
  output logic             rx_rst_o,
  output logic             tx_rst_o,
  output logic             to_restart_o,
  output logic [REG_W-1:0] rdata_o
);
  localparam int NPULSE = 3;
  localparam int PULSE_BIT [NPULSE] = '{B_RX_RST, B_TX_RST, B_TO_RST};

  logic [CTRL_W-1:0] ctrl_q;
  logic [NPULSE-1:0] pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RESET;
    end else if (we_i) begin
      ctrl_q <= wdata_i[CTRL_W-1:0] & ~CTRL_SELF_CLR;
    end
  end

  for (genvar i = 0; i < NPULSE; i++) begin : g_pulse
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pulse_q[i] <= 1'b0;
      else         pulse_q[i] <= we_i & wdata_i[PULSE_BIT[i]];
    end
  end

  if (REG_W > CTRL_W) begin : g_wide
    logic unused_hi;
    assign unused_hi = ^wdata_i[REG_W-1:CTRL_W];
    assign rdata_o   = {{(REG_W-CTRL_W){1'b0}}, ctrl_q};
  end else begin : g_narrow
    assign rdata_o = ctrl_q[REG_W-1:0];
  end

  assign rx_act_o     = ctrl_q[B_RX_EN] & ~ctrl_q[B_RX_DIS];
  assign tx_act_o     = ctrl_q[B_TX_EN] & ~ctrl_q[B_TX_DIS];
  assign brk_o        = ctrl_q[B_BRK_GO] & ~ctrl_q[B_BRK_END];
  assign rx_rst_o     = pulse_q[0];
  assign tx_rst_o     = pulse_q[1];
  assign to_restart_o = pulse_q[2];
endmodule

// File: rtl/uart_mode_reg.sv
module uart_mode_reg
  import uart_chan_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output ch_mode_e         mode_o
);
  ch_mode_e mode_q;
  logic     unused_bits;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mode_q <= CH_NORMAL;
    else if (we_i) mode_q <= ch_mode_e'(wdata_i[MODE_LSB+1:MODE_LSB]);
  end

  assign unused_bits = ^{wdata_i[REG_W-1:MODE_LSB+2], wdata_i[MODE_LSB-1:0]};
  assign mode_o      = mode_q;
endmodule

// File: rtl/uart_path_router.sv
module uart_path_router
  import uart_chan_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  ch_mode_e          mode_i,
  input  logic              rx_act_i,
  input  logic              tx_act_i,
  input  logic              rx_rst_i,
  input  logic              tx_rst_i,
  input  logic              line_valid_i,
  input  logic [DATA_W-1:0] line_data_i,
  input  logic              line_break_i,
  output logic              line_ready_o,
  input  logic              host_wr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  input  logic              host_rd_i,
  output logic [DATA_W-1:0] host_rdata_o,
  input  logic              rx_full_i,
  input  logic              rx_empty_i,
  input  logic [DATA_W-1:0] rx_head_i,
  input  logic              tx_full_i,
  output logic              rx_push_o,
  output logic [DATA_W-1:0] rx_push_data_o,
  output logic              rx_pop_o,
  output logic              tx_push_o,
  output logic [DATA_W-1:0] tx_push_data_o
);
  logic line_to_rx, line_to_tx, rx_ok, tx_ok, line_fire;
  logic brk_push, line_rx_push, host_rx_push, line_tx_push, host_tx_push;

  always_comb begin
    line_to_rx = (mode_i == CH_NORMAL) || (mode_i == CH_ECHO);
    line_to_tx = (mode_i == CH_ECHO)   || (mode_i == CH_REMOTE_LB);
    // reset pulse cycle blocks traffic into the FIFO being cleared
    rx_ok = rx_act_i & ~rx_rst_i & ~rx_full_i;
    tx_ok = tx_act_i & ~tx_rst_i & ~tx_full_i;

    line_ready_o = ~line_break_i & ~(line_to_rx & rx_full_i) & ~(line_to_tx & tx_full_i);
    line_fire    = line_valid_i & line_ready_o;

    brk_push     = line_break_i & rx_ok;
    line_rx_push = line_fire & line_to_rx & rx_ok;
    host_rx_push = host_wr_i & (mode_i == CH_LOCAL_LB) & rx_ok & ~line_break_i;
    line_tx_push = line_fire & line_to_tx & tx_ok;
    host_tx_push = host_wr_i & (mode_i == CH_NORMAL) & tx_ok;

    rx_push_o = brk_push | line_rx_push | host_rx_push;
    if (brk_push)          rx_push_data_o = '0;
    else if (line_rx_push) rx_push_data_o = line_data_i;
    else if (host_rx_push) rx_push_data_o = host_wdata_i;
    else                   rx_push_data_o = '0;

    tx_push_o = line_tx_push | host_tx_push;
    if (line_tx_push)      tx_push_data_o = line_data_i;
    else if (host_tx_push) tx_push_data_o = host_wdata_i;
    else                   tx_push_data_o = '0;

    rx_pop_o     = host_rd_i & rx_act_i & ~rx_rst_i & ~rx_empty_i;
    host_rdata_o = rx_pop_o ? rx_head_i : '0;
  end
endmodule

// File: rtl/uart_chan_router.sv
module uart_chan_router
  import uart_chan_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int REG_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [REG_W-1:0]  ctrl_wdata_i,
  output logic [REG_W-1:0]  ctrl_rdata_o,
  input  logic              mode_we_i,
  input  logic [REG_W-1:0]  mode_wdata_i,
  output logic [1:0]        mode_o,
  input  logic              line_valid_i,
  input  logic [DATA_W-1:0] line_data_i,
  input  logic              line_break_i,
  output logic              line_ready_o,
  input  logic              host_wr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  input  logic              host_rd_i,
  output logic [DATA_W-1:0] host_rdata_o,
  input  logic              rx_full_i,
  input  logic              rx_empty_i,
  input  logic [DATA_W-1:0] rx_head_i,
  input  logic              tx_full_i,
  output logic              rx_push_o,
  output logic [DATA_W-1:0] rx_push_data_o,
  output logic              rx_pop_o,
  output logic              tx_push_o,
  output logic [DATA_W-1:0] tx_push_data_o,
  output logic              rx_rst_o,
  output logic              tx_rst_o,
  output logic              to_restart_o,
  output logic              break_o
);
  logic     rx_act, tx_act;
  ch_mode_e mode;

  uart_ctrl_reg #(.REG_W(REG_W)) u_ctrl (
    .clk_i, .rst_ni,
    .we_i        (ctrl_we_i),
    .wdata_i     (ctrl_wdata_i),
    .rx_act_o    (rx_act),
    .tx_act_o    (tx_act),
    .brk_o       (break_o),
    .rx_rst_o    (rx_rst_o),
    .tx_rst_o    (tx_rst_o),
    .to_restart_o(to_restart_o),
    .rdata_o     (ctrl_rdata_o)
  );

  uart_mode_reg #(.REG_W(REG_W)) u_mode (
    .clk_i, .rst_ni,
    .we_i   (mode_we_i),
    .wdata_i(mode_wdata_i),
    .mode_o (mode)
  );

  assign mode_o = mode;

  uart_path_router #(.DATA_W(DATA_W)) u_route (
    .mode_i        (mode),
    .rx_act_i      (rx_act),
    .tx_act_i      (tx_act),
    .rx_rst_i      (rx_rst_o),
    .tx_rst_i      (tx_rst_o),
    .line_valid_i, .line_data_i, .line_break_i, .line_ready_o,
    .host_wr_i, .host_wdata_i, .host_rd_i, .host_rdata_o,
    .rx_full_i, .rx_empty_i, .rx_head_i, .tx_full_i,
    .rx_push_o, .rx_push_data_o, .rx_pop_o,
    .tx_push_o, .tx_push_data_o
  );
endmodule

// File: rtl/uart_chan_router_chk.sv
module uart_chan_router_chk #(
  parameter int DATA_W = 8,
  parameter int REG_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ctrl_we_i,
  input logic [REG_W-1:0]  ctrl_wdata_i,
  input logic [REG_W-1:0]  ctrl_rdata_o,
  input logic [1:0]        mode_o,
  input logic              line_break_i,
  input logic              line_ready_o,
  input logic              rx_full_i,
  input logic              rx_empty_i,
  input logic              tx_full_i,
  input logic              rx_push_o,
  input logic [DATA_W-1:0] rx_push_data_o,
  input logic              rx_pop_o,
  input logic              tx_push_o,
  input logic              rx_rst_o,
  input logic              tx_rst_o,
  input logic              break_o
);
  assert_rx_rst_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i && ctrl_wdata_i[0] |=> rx_rst_o && !ctrl_rdata_o[0]);
  assert_rx_rst_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctrl_we_i && ctrl_wdata_i[0]) |=> !rx_rst_o);
  assert_tx_rst_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctrl_we_i && ctrl_wdata_i[1]) |=> !tx_rst_o);
  assert_rx_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_o || rx_pop_o |-> ctrl_rdata_o[2] && !ctrl_rdata_o[3]);
  assert_tx_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_push_o |-> ctrl_rdata_o[4] && !ctrl_rdata_o[5]);
  assert_local_no_tx_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 2'd2 |-> !tx_push_o);
  assert_break_req_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i && ctrl_wdata_i[7] && !ctrl_wdata_i[8] |=> break_o);
  assert_break_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_break_i && rx_push_o |-> rx_push_data_o == '0 && !line_ready_o);
  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_push_o && rx_full_i) && !(tx_push_o && tx_full_i));
  assert_no_underflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop_o |-> !rx_empty_i);
  assert_reset_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_rst_o && (rx_push_o || rx_pop_o)) && !(tx_rst_o && tx_push_o));
endmodule

bind uart_chan_router uart_chan_router_chk #(.DATA_W(DATA_W), .REG_W(REG_W)) u_chk (
  .clk_i, .rst_ni, .ctrl_we_i, .ctrl_wdata_i, .ctrl_rdata_o, .mode_o,
  .line_break_i, .line_ready_o, .rx_full_i, .rx_empty_i, .tx_full_i,
  .rx_push_o, .rx_push_data_o, .rx_pop_o, .tx_push_o,
  .rx_rst_o, .tx_rst_o, .break_o
);

// File: tb/uart_chan_router_bench.sv
module uart_chan_router_bench;
  localparam int DW = 8;
  localparam int RW = 16;
  localparam logic [DW-1:0] LINE_B = 8'hA5;
  localparam logic [DW-1:0] HOST_B = 8'h3C;
  localparam logic [DW-1:0] HEAD_B = 8'h5A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctrl_we = 0, mode_we = 0;
  logic [RW-1:0] ctrl_wd = '0, mode_wd = '0, ctrl_rd;
  logic [1:0] mode;
  logic lv = 0, brk = 0, hw = 0, hr = 0, rxf = 0, rxe = 1, txf = 0;
  logic ready, rx_push, rx_pop, tx_push, rx_rst, tx_rst, to_rst, brk_req;
  logic [DW-1:0] host_rd, rx_pd, tx_pd;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  uart_chan_router #(.DATA_W(DW), .REG_W(RW)) u_uart_chan_router (
    .clk_i(clk), .rst_ni(rst_n),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wd), .ctrl_rdata_o(ctrl_rd),
    .mode_we_i(mode_we), .mode_wdata_i(mode_wd), .mode_o(mode),
    .line_valid_i(lv), .line_data_i(LINE_B), .line_break_i(brk), .line_ready_o(ready),
    .host_wr_i(hw), .host_wdata_i(HOST_B), .host_rd_i(hr), .host_rdata_o(host_rd),
    .rx_full_i(rxf), .rx_empty_i(rxe), .rx_head_i(HEAD_B), .tx_full_i(txf),
    .rx_push_o(rx_push), .rx_push_data_o(rx_pd), .rx_pop_o(rx_pop),
    .tx_push_o(tx_push), .tx_push_data_o(tx_pd),
    .rx_rst_o(rx_rst), .tx_rst_o(tx_rst), .to_restart_o(to_rst), .break_o(brk_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [RW-1:0] v);
    @(negedge clk); ctrl_we = 1; ctrl_wd = v;
    @(negedge clk); ctrl_we = 0; ctrl_wd = '0;
  endtask

  task automatic wr_mode(input logic [1:0] m);
    @(negedge clk); mode_we = 1; mode_wd = RW'(m) << 8;
    @(negedge clk); mode_we = 0; mode_wd = '0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ctrl", 32'(ctrl_rd), 32'h128);
    chk("R1 pulses/break", {rx_rst, tx_rst, to_rst, brk_req}, 0);
    chk("R1 mode", 32'(mode), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 disabled push", {rx_push, tx_push}, 0);

    // R2 self-clearing pulses, R6 break request
    wr_ctrl(16'h0043 | 16'h0094);
    chk("R2 pulses", {rx_rst, tx_rst, to_rst}, 3'b111);
    chk("R2 readback", 32'(ctrl_rd), 32'h094);
    chk("R6 break on", 32'(brk_req), 1);
    @(negedge clk);
    chk("R2 single cycle", {rx_rst, tx_rst, to_rst}, 0);
    wr_ctrl(16'h0194);
    chk("R6 stop wins", 32'(brk_req), 0);
    wr_ctrl(16'h0002);
    chk("R2 tx only", {rx_rst, tx_rst, to_rst}, 3'b010);
    wr_ctrl(16'h0040);
    chk("R2 restart only", {rx_rst, tx_rst, to_rst}, 3'b001);

    // R10 reset pulse vs concurrent line byte, normal mode
    wr_mode(2'd0);
    rxe = 1; lv = 1;
    wr_ctrl(16'h0015);
    chk("R10 push masked in pulse", {rx_rst, rx_push}, 2'b10);
    @(negedge clk);
    chk("R10 push after pulse", {rx_rst, rx_push, 8'(rx_pd)}, {2'b01, LINE_B});
    lv = 0;

    // R3 R4 R5 R7 R8 R9 exhaustive sweep
    for (int m = 0; m < 4; m++) begin
      wr_mode(2'(m));
      chk("R4 mode readback", 32'(mode), 32'(m));
      for (int c = 0; c < 16; c++) begin
        wr_ctrl(RW'(c) << 2);
        for (int s = 0; s < 128; s++) begin
          logic rxa, txa, to_rx, to_tx, e_rdy, e_rxp, e_txp, e_pop;
          logic [DW-1:0] e_rxd, e_txd, e_hrd;
          @(negedge clk);
          {lv, brk, hw, hr, rxf, rxe, txf} = 7'(s);
          #1;
          rxa = c[0] && !c[1];
          txa = c[2] && !c[3];
          to_rx = (m == 0) || (m == 1);
          to_tx = (m == 1) || (m == 3);
          e_rdy = !brk && !(to_rx && rxf) && !(to_tx && txf);
          e_rxp = 0; e_rxd = '0;
          if (rxa && !rxf) begin
            if (brk) begin e_rxp = 1; e_rxd = '0; end
            else if (lv && e_rdy && to_rx) begin e_rxp = 1; e_rxd = LINE_B; end
            else if (hw && m == 2) begin e_rxp = 1; e_rxd = HOST_B; end
          end
          e_txp = 0; e_txd = '0;
          if (txa && !txf) begin
            if (lv && e_rdy && to_tx) begin e_txp = 1; e_txd = LINE_B; end
            else if (hw && m == 0) begin e_txp = 1; e_txd = HOST_B; end
          end
          e_pop = hr && rxa && !rxe;
          e_hrd = e_pop ? HEAD_B : '0;
          chk("R3 R4 R5 R7 R8 R9 route",
              {ready, rx_push, rx_pd, tx_push, tx_pd, rx_pop, host_rd},
              {e_rdy, e_rxp, e_rxd, e_txp, e_txd, e_pop, e_hrd});
        end
        {lv, brk, hw, hr, rxf, rxe, txf} = 7'b0000010;
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule